// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address that a synchronous SRAM core uses on each cycle of a four-beat burst. A load cycle with the part selected captures an external start address and opens a burst. Each following advance cycle steps the two low address bits to the next beat while the upper bits stay fixed. A deselect on a load cycle closes the burst.

A static order input picks one of two beat orders. The linear order counts the low bits up modulo four from the loaded value. The interleaved order forms the low bits as the loaded low bits XOR the beat number. Past the fourth beat, further advances wrap back to the first beat of the same burst. A stall input freezes every register, so the outputs stay as if that clock edge had not happened. The block reports the current address, whether a burst is open, and whether the last accepted cycle moved a beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0, burst_o is 0 and xfer_o is 0.
- R2: A non-stalled cycle with adv_i=0 and sel_i=1 loads addr_i. From the next cycle addr_o equals the loaded address (beat 0), burst_o=1 and xfer_o=1. This also applies in the middle of an open burst, and the new burst restarts at beat 0.
- R3: A non-stalled cycle with adv_i=0 and sel_i=0 closes any burst. Next cycle burst_o=0 and xfer_o=0, and addr_o is unchanged.
- R4: A non-stalled cycle with adv_i=1 and a burst open advances one beat and sets xfer_o=1. addr_i is ignored, and addr_o bits above bit 1 do not change.
- R5: With order_i=0 (linear), the low two bits of beat k are (loaded low bits + k) mod 4. No carry reaches bit 2.
- R6: With order_i=1 (interleaved), the low two bits of beat k are the loaded low bits XOR k.
- R7: The advance after beat 3 returns addr_o to the beat 0 address of the same burst, and the burst stays open.
- R8: A non-stalled cycle with adv_i=1 and no burst open leaves addr_o unchanged. Next cycle xfer_o=0 and burst_o=0.
- R9: A cycle with stall_i=1 leaves addr_o, burst_o and xfer_o unchanged, whatever adv_i, sel_i and addr_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 = ignore this edge, hold all state |
| adv_i | input | 1 | 1 = advance burst, 0 = load or deselect |
| sel_i | input | 1 | Combined chip select, 1 = selected |
| order_i | input | 1 | Static beat order, 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |
| burst_o | output | 1 | A burst is open |
| xfer_o | output | 1 | Last accepted cycle was a load or an advancing beat |

## Verification
Some rules are checked by assertions on every cycle: the result of a load, the close on deselect, the fixed upper bits while advancing, the step in the low bits for each order, the wrap from beat 3 to beat 0, an idle advance doing nothing, and stalls freezing state. Only the bench scenarios show the actual address values over a full burst. These include the reset state, complete linear and interleaved sequences from chosen start addresses, a linear start at low bits 3 with all upper bits set, and a reload in the middle of a burst. They also show that addr_i is truly ignored while advancing or stalled.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STOP = 2'd2,
    CMD_STEP = 2'd3
  } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic       stall_i,
  input  logic       adv_i,
  input  logic       sel_i,
  output burst_cmd_e cmd_o
);
  always_comb begin
    if (stall_i)      cmd_o = CMD_HOLD;
    else if (adv_i)   cmd_o = CMD_STEP;
    else if (sel_i)   cmd_o = CMD_LOAD;
    else              cmd_o = CMD_STOP;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_cmd_e        cmd_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              active_o,
  output logic              xfer_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o   <= '0;
      active_o <= 1'b0;
      xfer_o   <= 1'b0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          beat_o   <= '0;
          active_o <= 1'b1;
          xfer_o   <= 1'b1;
        end
        CMD_STOP: begin
          active_o <= 1'b0;
          xfer_o   <= 1'b0;
        end
        CMD_STEP: begin
          // wraps naturally after the last beat
          if (active_o) beat_o <= beat_o + ONE;
          xfer_o <= active_o;
        end
        default: ;
      endcase
    end
  end

  a_r2_load_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_LOAD |=> beat_o == '0 && active_o && xfer_o);
  a_r3_stop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STOP |=> !active_o && !xfer_o && $stable(beat_o));
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP && active_o && beat_o == {BEAT_W{1'b1}} |=> beat_o == '0 && active_o);
  a_r8_idle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP && !active_o |=> !xfer_o && !active_o && $stable(beat_o));
  a_r9_hold_ctr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_HOLD |=> $stable(beat_o) && $stable(active_o) && $stable(xfer_o));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_cmd_e        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                base_o <= '0;
    else if (cmd_i == CMD_LOAD) base_o <= addr_i;
  end

  a_r4_base_ignores_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != CMD_LOAD |=> $stable(base_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_i + beat_i;  // truncation keeps the wrap inside the burst

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = order_i ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_o,
  output logic              xfer_o
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  burst_cmd_e        cmd;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] low;

  burst_cmd_decode u_dec (
    .stall_i (stall_i),
    .adv_i   (adv_i),
    .sel_i   (sel_i),
    .cmd_o   (cmd)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .beat_o   (beat),
    .active_o (burst_o),
    .xfer_o   (xfer_o)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .addr_i (addr_i),
    .base_o (base)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order_i),
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};

  a_r2_load_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && !adv_i && sel_i |=> addr_o == $past(addr_i) && burst_o && xfer_o);
  a_r4_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && adv_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
  a_r5_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && adv_i && burst_o && !order_i |=>
      (!$stable(order_i) || addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + ONE));
  a_r6_ilv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && adv_i && burst_o && order_i |=>
      (!$stable(order_i) ||
       (addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == ($past(beat) ^ ($past(beat) + ONE))));
  a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]) && $stable(burst_o) && $stable(xfer_o));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stall_i = 1'b0;
  logic          adv_i = 1'b1;
  logic          sel_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          burst_o;
  logic          xfer_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .adv_i(adv_i),
    .sel_i(sel_i), .order_i(order_i), .addr_i(addr_i),
    .addr_o(addr_o), .burst_o(burst_o), .xfer_o(xfer_o)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] start, int k, logic ilv);
    logic [1:0] kk = 2'(k);
    logic [1:0] lo = ilv ? (start[1:0] ^ kk) : 2'(start[1:0] + kk);
    return {start[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(string req, logic [AW-1:0] ea, logic eb, logic ex);
    check(req, 32'(addr_o), 32'(ea));
    check(req, 32'(burst_o), 32'(eb));
    check(req, 32'(xfer_o), 32'(ex));
  endtask

  // drive at a negedge, return at the next negedge (one rising edge later)
  task automatic cyc(logic st, logic ad, logic se, logic [AW-1:0] a);
    stall_i = st; adv_i = ad; sel_i = se; addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check_out("R1", '0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_burst(string req, logic ilv, logic [AW-1:0] start);
    order_i = ilv;
    cyc(0, 0, 1, start);
    check_out("R2", start, 1'b1, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      cyc(0, 1, 1, AW'(32'h5A5A5 * k));
      if (k >= 4) check_out("R7", exp_addr(start, k, ilv), 1'b1, 1'b1);
      else        check_out(req, exp_addr(start, k, ilv), 1'b1, 1'b1);
    end
  endtask

  task automatic t_carry();
    order_i = 1'b0;
    cyc(0, 0, 1, 19'h7FFFF);
    cyc(0, 1, 0, 19'h00000);
    check_out("R5", 19'h7FFFC, 1'b1, 1'b1);
  endtask

  task automatic t_deselect();
    order_i = 1'b0;
    cyc(0, 0, 1, 19'h10004);
    cyc(0, 1, 1, 19'h22222);
    check_out("R4", 19'h10005, 1'b1, 1'b1);
    cyc(0, 0, 0, 19'h33333);
    check_out("R3", 19'h10005, 1'b0, 1'b0);
    cyc(0, 1, 1, 19'h44444);
    check_out("R8", 19'h10005, 1'b0, 1'b0);
    cyc(0, 1, 1, 19'h44444);
    check_out("R8", 19'h10005, 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    order_i = 1'b0;
    cyc(0, 0, 1, 19'h03000);
    cyc(0, 1, 1, 19'h0);
    check_out("R4", 19'h03001, 1'b1, 1'b1);
    cyc(1, 1, 1, 19'h0);
    check_out("R9", 19'h03001, 1'b1, 1'b1);
    cyc(1, 0, 1, 19'h55555);
    check_out("R9", 19'h03001, 1'b1, 1'b1);
    cyc(1, 0, 0, 19'h55555);
    check_out("R9", 19'h03001, 1'b1, 1'b1);
    cyc(0, 1, 1, 19'h55555);
    check_out("R4", 19'h03002, 1'b1, 1'b1);
    // stall after a deselect keeps xfer low
    cyc(0, 0, 0, 19'h0);
    cyc(1, 0, 1, 19'h12345);
    check_out("R9", 19'h03002, 1'b0, 1'b0);
  endtask

  task automatic t_reload();
    order_i = 1'b1;
    cyc(0, 0, 1, 19'h00101);
    cyc(0, 1, 1, 19'h0);
    cyc(0, 1, 1, 19'h0);
    check_out("R6", 19'h00103, 1'b1, 1'b1);
    cyc(0, 0, 1, 19'h6000E);
    check_out("R2", 19'h6000E, 1'b1, 1'b1);
    cyc(0, 1, 1, 19'h0);
    check_out("R6", 19'h6000F, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_burst("R5", 1'b0, 19'h01235);
    t_burst("R6", 1'b1, 19'h002A6);
    t_burst("R6", 1'b1, 19'h40001);
    t_carry();
    t_deselect();
    t_stall();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule